// File: doc/BRIEF.md
# Instruction Loop Buffer with Halt-Mode Side Buffer

This block sits between the fetch stage of a small signal-processing core and its program memory. Every cycle the core may present a fetch address, together with a flag saying whether that address is the target of a taken change of control flow. The block uses those flow-change flags, not a tag lookup on every fetch, to spot a loop. A flow change whose target lies at or below the previous fetch address marks the start of a loop. The block then captures the instructions of that pass into a small buffer. On every later pass it serves them from the buffer and holds the program memory enable low. If the loop body is longer than the buffer, only its leading part is kept and the tail keeps coming from memory.

While the core is halted the loop buffer is switched off. A tiny direct-mapped side buffer takes its place. It holds the few no-op words fetched around a one-instruction interrupt handler, so that repeated wake-ups do not touch program memory. A build-time option adds a count-based release. Once a fixed number of memory-served fetches have occurred in a row with a loop active, the loop buffer is dropped.

Program memory has a one-cycle synchronous read. The instruction for a fetch accepted in one cycle is delivered in the next cycle, whichever source served it.

Top module: `lc_top`

## Requirements
- R1: After reset, `instrValid` and `memEn` are low, and both buffers are empty, so the first fetches are served from memory.
- R2: `instrValid` is high in the cycle after each cycle with `fetchReq` high, and low otherwise. `instrData` then equals the program memory word at the requested address, whatever source served it.
- R3: `memEn` is high exactly in the cycles where `fetchReq` is high and neither buffer serves the fetch. `memAddr` always equals `fetchAddr`.
- R4: With no loop held and the core not halted, a fetch with `flowChg` high whose address is at or below the previous fetch address records that address as the loop start. The fetch is served from memory, and that pass is captured. From the next `flowChg` fetch to the same start address onward, captured words are served from the buffer.
- R5: A loop body longer than `LOOP_DEPTH` words has its first `LOOP_DEPTH` words buffered. The remaining words of each pass are fetched from memory.
- R6: When a loop is held, a `flowChg` fetch to any address other than the loop start empties the loop buffer and returns it to idle. That fetch is served from memory.
- R7: With `MISS_RESET` set, after `MISS_LIMIT` consecutive memory-served sequential fetches while a loop is active, the loop buffer is emptied. A buffer hit restarts the count.
- R8: While `haltMode` is high, the loop buffer neither serves nor captures, and its contents and loop start are kept. Serving resumes once `haltMode` falls.
- R9: While `haltMode` is high, fetches use a direct-mapped side buffer of `HALT_DEPTH` words (a power of two), indexed by the low address bits. A miss fills the entry, a repeat of the same address hits, and a different address with the same index evicts it.
- R10: The side buffer is emptied whenever `haltMode` is low, so the first fetch of every halt period is served from memory.
- R11: A cycle with `fetchReq` low keeps `memEn` low and changes no buffer or loop state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fetchReq | input | 1 | Fetch request this cycle |
| fetchAddr | input | ADDR_W | Fetch address |
| flowChg | input | 1 | This fetch is the target of a taken control-flow change |
| haltMode | input | 1 | Core is halted; selects the side buffer |
| memEn | output | 1 | Program memory read enable |
| memAddr | output | ADDR_W | Program memory read address |
| memRdata | input | DATA_W | Program memory read data, one cycle after `memEn` |
| instrValid | output | 1 | Instruction delivered this cycle |
| instrData | output | DATA_W | Delivered instruction word |

## Verification
The properties assume the following about the inputs. `flowChg` is raised only together with `fetchReq`. Between flow changes, fetch addresses step up by one. Program memory returns the addressed word exactly one cycle after `memEn`, and address arithmetic never wraps. The stimulus meets these assumptions by placing each loop scenario in its own address region, at increasing addresses. Each scenario is entered by a forward jump, so a jump between scenarios never looks like a backward branch. The bench memory model answers only on enabled cycles.

// File: rtl/lc_pkg.sv
package lc_pkg;

  typedef enum logic [1:0] {
    LC_IDLE   = 2'd0,
    LC_FILL   = 2'd1,
    LC_ACTIVE = 2'd2
  } lcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic fetchGo;
    logic loopHit;
    logic loopCapture;
    logic haltOn;
  } lcStrobe_t;

endpackage

// File: rtl/lc_ctrl.sv
module lc_ctrl
  import lc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LOOP_DEPTH = 8,
  parameter int MISS_RESET = 1,
  parameter int MISS_LIMIT = 4,
  localparam int LIW = (LOOP_DEPTH > 1) ? $clog2(LOOP_DEPTH) : 1,
  localparam int CW  = $clog2(LOOP_DEPTH + 1),
  localparam int MCW = $clog2(MISS_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              flowChg,
  input  logic              haltMode,
  output lcStrobe_t         strb,
  output logic [LIW-1:0]    loopIdx
);

  lcState_t          state, nxt, nxtFinal;
  logic [ADDR_W-1:0] startAddr, lastAddr, offset;
  logic              lastVld;
  logic [CW-1:0]     validCnt;
  logic              run, backward, toStart, inBuf;
  logic              hit, capture, missStep, dropLoop;

  assign run      = fetchReq & ~haltMode;
  assign backward = flowChg & lastVld & (fetchAddr <= lastAddr);
  assign toStart  = flowChg & (fetchAddr == startAddr);
  assign offset   = fetchAddr - startAddr;
  assign inBuf    = offset < ADDR_W'(validCnt);

  always_comb begin
    nxt      = state;
    hit      = 1'b0;
    capture  = 1'b0;
    missStep = 1'b0;
    loopIdx  = offset[LIW-1:0];
    if (run) begin
      if (state == LC_IDLE) begin
        if (backward) begin
          nxt     = LC_FILL;
          capture = 1'b1;
          loopIdx = '0;
        end
      end else if (flowChg && !toStart) begin
        nxt = LC_IDLE;
      end else if (toStart) begin
        nxt     = LC_ACTIVE;
        hit     = 1'b1;
        loopIdx = '0;
      end else if (inBuf) begin
        hit = 1'b1;
      end else if (state == LC_FILL && offset == ADDR_W'(validCnt)
                   && validCnt < CW'(LOOP_DEPTH)) begin
        capture = 1'b1;
      end else if (state == LC_ACTIVE) begin
        missStep = 1'b1;
      end
    end
  end

  generate
    if (MISS_RESET != 0) begin : g_missReset
      logic [MCW-1:0] missCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                               missCnt <= '0;
        else if (nxtFinal != LC_ACTIVE || hit)   missCnt <= '0;
        else if (missStep)                       missCnt <= missCnt + 1'b1;
      end
      assign dropLoop = missStep && (missCnt == MCW'(MISS_LIMIT - 1));
    end else begin : g_noReset
      assign dropLoop = 1'b0;
    end
  endgenerate

  assign nxtFinal = dropLoop ? LC_IDLE : nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= LC_IDLE;
      startAddr <= '0;
      lastAddr  <= '0;
      lastVld   <= 1'b0;
      validCnt  <= '0;
    end else begin
      if (fetchReq) begin
        lastAddr <= fetchAddr;
        lastVld  <= 1'b1;
      end
      state <= nxtFinal;
      if (nxtFinal == LC_IDLE) begin
        validCnt <= '0;
      end else if (capture) begin
        validCnt <= validCnt + 1'b1;
        if (state == LC_IDLE) startAddr <= fetchAddr;
      end
    end
  end

  assign strb.fetchGo     = fetchReq;
  assign strb.loopHit     = hit;
  assign strb.loopCapture = capture;
  assign strb.haltOn      = haltMode;

endmodule

// File: rtl/lc_dpath.sv
module lc_dpath
  import lc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 16,
  parameter int LOOP_DEPTH = 8,
  parameter int HALT_DEPTH = 2,
  localparam int LIW = (LOOP_DEPTH > 1) ? $clog2(LOOP_DEPTH) : 1,
  localparam int HIW = (HALT_DEPTH > 1) ? $clog2(HALT_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  lcStrobe_t         strb,
  input  logic [LIW-1:0]    loopIdx,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic              haltHit,
  output logic              instrValid,
  output logic [DATA_W-1:0] instrData
);

  logic [DATA_W-1:0]     loopMem  [LOOP_DEPTH];
  logic [DATA_W-1:0]     haltData [HALT_DEPTH];
  logic [ADDR_W-1:0]     haltTag  [HALT_DEPTH];
  logic [HALT_DEPTH-1:0] haltVld;
  logic [HIW-1:0]        haltIdx, dHaltIdx;
  logic [LIW-1:0]        dLoopIdx;
  logic                  haltFill, dLoop, dHalt, dCap, dHaltFill;

  generate
    if (HALT_DEPTH > 1) begin : g_haltIdx
      assign haltIdx = fetchAddr[HIW-1:0];
    end else begin : g_haltOne
      assign haltIdx = '0;
    end
  endgenerate

  assign haltHit  = strb.haltOn & strb.fetchGo & haltVld[haltIdx]
                  & (haltTag[haltIdx] == fetchAddr);
  assign haltFill = strb.haltOn & strb.fetchGo & ~haltHit;

  // side-buffer tags: emptied outside halt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltVld <= '0;
      for (int i = 0; i < HALT_DEPTH; i++) haltTag[i] <= '0;
    end else if (!strb.haltOn) begin
      haltVld <= '0;
    end else if (haltFill) begin
      haltVld[haltIdx] <= 1'b1;
      haltTag[haltIdx] <= fetchAddr;
    end
  end

  // second stage: what serves the word now arriving
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instrValid <= 1'b0;
      dLoop      <= 1'b0;
      dHalt      <= 1'b0;
      dCap       <= 1'b0;
      dHaltFill  <= 1'b0;
      dLoopIdx   <= '0;
      dHaltIdx   <= '0;
    end else begin
      instrValid <= strb.fetchGo;
      dLoop      <= strb.loopHit;
      dHalt      <= haltHit;
      dCap       <= strb.loopCapture;
      dHaltFill  <= haltFill;
      dLoopIdx   <= loopIdx;
      dHaltIdx   <= haltIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (dCap)      loopMem[dLoopIdx]  <= memRdata;
    if (dHaltFill) haltData[dHaltIdx] <= memRdata;
  end

  assign instrData = dLoop ? loopMem[dLoopIdx]
                   : dHalt ? haltData[dHaltIdx]
                   : memRdata;

endmodule

// File: rtl/lc_top.sv
module lc_top
  import lc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 16,
  parameter int LOOP_DEPTH = 8,
  parameter int HALT_DEPTH = 2,
  parameter int MISS_RESET = 1,
  parameter int MISS_LIMIT = 4,
  localparam int LIW = (LOOP_DEPTH > 1) ? $clog2(LOOP_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              flowChg,
  input  logic              haltMode,
  output logic              memEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic              instrValid,
  output logic [DATA_W-1:0] instrData
);

  lcStrobe_t      strb;
  logic [LIW-1:0] loopIdx;
  logic           haltHit;

  lc_ctrl #(
    .ADDR_W(ADDR_W), .LOOP_DEPTH(LOOP_DEPTH),
    .MISS_RESET(MISS_RESET), .MISS_LIMIT(MISS_LIMIT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .flowChg(flowChg), .haltMode(haltMode), .strb(strb), .loopIdx(loopIdx)
  );

  lc_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LOOP_DEPTH(LOOP_DEPTH), .HALT_DEPTH(HALT_DEPTH)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .loopIdx(loopIdx),
    .fetchAddr(fetchAddr), .memRdata(memRdata), .haltHit(haltHit),
    .instrValid(instrValid), .instrData(instrData)
  );

  assign memEn   = fetchReq & ~strb.loopHit & ~haltHit;
  assign memAddr = fetchAddr;

endmodule

// File: rtl/lc_top_chk.sv
module lc_top_chk
  import lc_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      fetchReq,
  input logic      haltMode,
  input logic      memEn,
  input logic      instrValid,
  input lcStrobe_t strb,
  input logic      haltHit
);

  // R3
  mem_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fetchReq |-> !memEn);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |=> instrValid);

  // R11
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fetchReq |=> !instrValid);

  // R8
  halt_loop_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltMode |-> !strb.loopHit && !strb.loopCapture);

  // R4
  hit_cap_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loopHit && strb.loopCapture));

  // R9
  halt_hit_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltHit |-> haltMode && fetchReq);

endmodule

bind lc_top lc_top_chk chk_i (
  .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .haltMode(haltMode),
  .memEn(memEn), .instrValid(instrValid), .strb(strb), .haltHit(haltHit)
);

// File: tb/lc_top_tb_top.sv
`timescale 1ns/1ps
module lc_top_tb_top;

  localparam int AW    = 12;
  localparam int DW    = 16;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          fetchReq = 1'b0;
  logic [AW-1:0] fetchAddr = '0;
  logic          flowChg = 1'b0;
  logic          haltMode = 1'b0;
  logic          memEn;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memRdata = '0;
  logic          instrValid;
  logic [DW-1:0] instrData;

  int checks = 0;
  int fails  = 0;
  logic          prevReq = 1'b0;
  logic [AW-1:0] prevAddr = '0;

  always #2.5 clk = ~clk;

  lc_top #(
    .ADDR_W(AW), .DATA_W(DW), .LOOP_DEPTH(DEPTH), .HALT_DEPTH(2),
    .MISS_RESET(1), .MISS_LIMIT(4)
  ) dut_i (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .flowChg(flowChg), .haltMode(haltMode), .memEn(memEn), .memAddr(memAddr),
    .memRdata(memRdata), .instrValid(instrValid), .instrData(instrData)
  );

  function automatic logic [DW-1:0] memWord(input logic [AW-1:0] a);
    logic [15:0] p;
    p = {4'b0, a} * 16'd40503;
    return p ^ 16'h5A5A;
  endfunction

  // program memory model: one-cycle synchronous read
  always @(posedge clk) if (memEn) memRdata <= memWord(memAddr);

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit req, input int a, input bit fc, input bit hl,
                      input bit expEn, input string tag);
    @(negedge clk);
    fetchReq  = req;
    fetchAddr = AW'(a);
    flowChg   = fc;
    haltMode  = hl;
    #1;
    chk(instrValid == prevReq, "R2 valid", 32'(instrValid), 32'(prevReq));
    if (prevReq)
      chk(instrData == memWord(prevAddr), "R2 data", 32'(instrData), 32'(memWord(prevAddr)));
    chk(memEn == (req & expEn), {tag, " memEn"}, 32'(memEn), 32'(req & expEn));
    if (memEn) chk(memAddr == AW'(a), "R3 addr", 32'(memAddr), 32'(a));
    prevReq  = req;
    prevAddr = AW'(a);
  endtask

  // forward entry at base, two straight words, then passes over [base+2, +len)
  task automatic runLoop(input int base, input int len, input int passes);
    int s;
    int kept;
    s = base + 2;
    kept = (len < DEPTH) ? len : DEPTH;
    step(1, base, 1, 0, 1, "R6");
    step(1, base + 1, 0, 0, 1, "R4");
    for (int i = 0; i < passes; i++)
      for (int o = 0; o < len; o++)
        step(1, s + o, (i > 0 && o == 0), 0,
             (i >= 2 && o < kept) ? 1'b0 : 1'b1, (len > DEPTH) ? "R5" : "R4");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(instrValid == 1'b0, "R1 valid", 32'(instrValid), 0);
    chk(memEn == 1'b0, "R1 memEn", 32'(memEn), 0);

    // R4 / R5 sweep over loop lengths
    for (int len = 1; len <= 11; len++) runLoop(100 + 48 * len, len, 4);

    // R7 count-based release, with an idle cycle (R11)
    runLoop(1400, 5, 3);
    step(1, 1407, 0, 0, 1, "R7");
    step(1, 1408, 0, 0, 1, "R7");
    step(1, 1409, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 0, "R11");
    step(1, 1402, 1, 0, 0, "R7");
    for (int o = 1; o < 5; o++) step(1, 1402 + o, 0, 0, 0, "R7");
    for (int o = 5; o < 9; o++) step(1, 1402 + o, 0, 0, 1, "R7");
    step(1, 1402, 1, 0, 1, "R7");
    for (int o = 1; o < 5; o++) step(1, 1402 + o, 0, 0, 1, "R7");
    step(1, 1402, 1, 0, 0, "R7");
    step(1, 1403, 0, 0, 0, "R7");

    // R6 invalidation by a jump inside the loop
    runLoop(1600, 6, 3);
    step(1, 1602, 1, 0, 0, "R6");
    step(1, 1603, 0, 0, 0, "R6");
    step(1, 1606, 1, 0, 1, "R6");
    step(1, 1607, 0, 0, 1, "R6");
    step(1, 1602, 1, 0, 1, "R6");
    for (int o = 1; o < 6; o++) step(1, 1602 + o, 0, 0, 1, "R6");
    step(1, 1602, 1, 0, 0, "R6");
    for (int o = 1; o < 6; o++) step(1, 1602 + o, 0, 0, 0, "R6");

    // R8 / R9 / R10 halt behaviour
    runLoop(1800, 4, 3);
    step(1, 1802, 1, 1, 1, "R8");
    step(1, 2000, 0, 1, 1, "R9");
    step(1, 2001, 0, 1, 1, "R9");
    step(1, 2000, 0, 1, 0, "R9");
    step(1, 2001, 0, 1, 0, "R9");
    step(1, 2002, 0, 1, 1, "R9");
    step(1, 2000, 0, 1, 1, "R9");
    step(1, 2001, 0, 1, 0, "R9");
    step(1, 1802, 1, 0, 0, "R8");
    for (int o = 1; o < 4; o++) step(1, 1802 + o, 0, 0, 0, "R8");
    step(1, 2000, 1, 1, 1, "R10");
    step(1, 2000, 0, 1, 0, "R9");
    step(1, 1802, 1, 0, 0, "R8");
    step(0, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 0, 0, "R11");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule